// File: doc/BRIEF.md
# Width-Aware Status Flag Update Unit

This block owns the processor status word (PSW) and folds the arithmetic condition flags of one result into it. An execution stage presents a signed result of up to 64 bits, the operand size in bytes (1 to 4), a carry bit and a four-bit select that names which of carry, zero, sign and overflow this instruction is allowed to touch. The block derives the flags for the chosen width and writes the merged word on the next rising clock edge when the update strobe is high.

Every accepted update also applies three global masks to the whole word. First a force-clear (AND) mask, then a force-set (OR) mask, and finally the computed flags, limited by both the select and a permitted-flag mask, are ORed in. There is no state machine: the only state is the PSW register. It resets to zero, and it holds its value whenever the strobe is low or the size code is not 1 to 4.

Top module: `psw_flag_unit`

## Requirements
- R1: After reset `psw` reads 0.
- R2: While `upd_en` is low, `psw` keeps its value whatever the other inputs do.
- R3: An update with `op_size` equal to 0 or greater than 4 leaves `psw` unchanged.
- R4: The zero flag (PSW bit 1) is computed as 1 when the low `8*op_size` bits of `result` are all zero.
- R5: The sign flag (PSW bit 2) is computed as bit `8*op_size-1` of `result`.
- R6: The overflow flag (PSW bit 3) is computed as 1 when the full 64-bit signed `result` is above 2^(8*op_size-1)-1 or below -2^(8*op_size-1).
- R7: The carry flag (PSW bit 0) is computed as `carry_in`.
- R8: `flag_sel` bit 0 selects carry, bit 1 zero, bit 2 sign and bit 3 overflow. A computed flag whose select bit is 0 is not ORed into the PSW.
- R9: An accepted update writes `((psw & and_mask) | or_mask) | (flags & sel & allow_mask)`. Here `flags` and `sel` sit in bits 3:0, and `allow_mask` gates bit by bit.
- R10: PSW bits 31:4, including interrupt enable (16), user mode (17), processor mode (20) and priority level (27:24), change on an update only through `and_mask` and `or_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_en | input | 1 | Update strobe |
| result | input | 64 | Signed result to evaluate |
| op_size | input | 3 | Operand width in bytes, valid 1 to 4 |
| carry_in | input | 1 | Carry produced by the operation |
| flag_sel | input | 4 | Flags to update: bit0 C, bit1 Z, bit2 S, bit3 O |
| and_mask | input | 32 | Force-clear mask, ANDed first |
| or_mask | input | 32 | Force-set mask, ORed second |
| allow_mask | input | 32 | Permitted-flag mask on the computed flags |
| psw | output | 32 | Current processor status word |

## Verification
The assertions assume the inputs are at known, settled values at each rising edge. They also assume `result` is a true sign-extended 64-bit value, so the range test for overflow is meaningful. The bench drives every input at the falling edge and sweeps all eight size codes and all sixteen select patterns. It uses results placed on each width's signed and zero boundaries and rotates four mask sets that exercise clear-only, set-only and permitted-flag filtering. Each update is followed by an idle cycle that uses fresh, unrelated inputs.

// File: rtl/psw_flag_pkg.sv
package psw_flag_pkg;
    localparam int PSW_W    = 32;
    localparam int FLAG_N   = 4;
    localparam int BIT_C    = 0;
    localparam int BIT_Z    = 1;
    localparam int BIT_S    = 2;
    localparam int BIT_O    = 3;

    typedef struct packed {
        logic o;
        logic s;
        logic z;
        logic c;
    } flags_t;
endpackage

// File: rtl/psw_flag_calc.sv
module psw_flag_calc
    import psw_flag_pkg::*;
#(
    parameter int RES_W     = 64,
    parameter int BYTE_W    = 8,
    parameter int MAX_BYTES = 4,
    parameter int SIZE_W    = 3
) (
    input  logic [RES_W-1:0]  result,
    input  logic [SIZE_W-1:0] op_size,
    input  logic              carry_in,
    output flags_t            flags,
    output logic              size_ok
);
    logic [MAX_BYTES:1] zero_w;
    logic [MAX_BYTES:1] sign_w;
    logic [MAX_BYTES:1] ovf_w;

    for (genvar k = 1; k <= MAX_BYTES; k++) begin : g_width
        localparam int W = k * BYTE_W;
        // fits in signed W bits iff bits RES_W-1 .. W-1 are all equal
        logic [RES_W-W:0] upper;
        assign upper     = result[RES_W-1:W-1];
        assign zero_w[k] = (result[W-1:0] == '0);
        assign sign_w[k] = result[W-1];
        assign ovf_w[k]  = !((&upper) || (upper == '0));
    end

    always_comb begin
        size_ok = (op_size >= SIZE_W'(1)) && (op_size <= SIZE_W'(MAX_BYTES));
        flags   = '0;
        flags.c = carry_in;
        for (int k = 1; k <= MAX_BYTES; k++) begin
            if (op_size == SIZE_W'(k)) begin
                flags.z = zero_w[k];
                flags.s = sign_w[k];
                flags.o = ovf_w[k];
            end
        end
        // a zero value in the width cannot have its top bit set (R5)
        if (size_ok && flags.z)
            assert_zero_not_neg_R5: assert (!flags.s);
    end
endmodule

// File: rtl/psw_merge.sv
module psw_merge
    import psw_flag_pkg::*;
(
    input  logic [PSW_W-1:0] psw_q,
    input  flags_t           flags,
    input  logic [FLAG_N-1:0] flag_sel,
    input  logic [PSW_W-1:0] and_mask,
    input  logic [PSW_W-1:0] or_mask,
    input  logic [PSW_W-1:0] allow_mask,
    output logic [PSW_W-1:0] psw_d
);
    logic [PSW_W-1:0] flag_word;
    logic [PSW_W-1:0] forced;

    always_comb begin
        flag_word = '0;
        flag_word[BIT_C] = flags.c & flag_sel[BIT_C];
        flag_word[BIT_Z] = flags.z & flag_sel[BIT_Z];
        flag_word[BIT_S] = flags.s & flag_sel[BIT_S];
        flag_word[BIT_O] = flags.o & flag_sel[BIT_O];
        forced = (psw_q & and_mask) | or_mask;
        psw_d  = forced | (flag_word & allow_mask);
    end
endmodule

// File: rtl/psw_flag_unit.sv
module psw_flag_unit
    import psw_flag_pkg::*;
#(
    parameter int RES_W  = 64,
    parameter int SIZE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [RES_W-1:0]  result,
    input  logic [SIZE_W-1:0] op_size,
    input  logic              carry_in,
    input  logic [3:0]        flag_sel,
    input  logic [31:0]       and_mask,
    input  logic [31:0]       or_mask,
    input  logic [31:0]       allow_mask,
    output logic [31:0]       psw
);
    flags_t           flags;
    logic             size_ok;
    logic [PSW_W-1:0] psw_d;
    logic [PSW_W-1:0] psw_q;

    psw_flag_calc #(
        .RES_W(RES_W), .BYTE_W(8), .MAX_BYTES(4), .SIZE_W(SIZE_W)
    ) u_calc (
        .result(result), .op_size(op_size), .carry_in(carry_in),
        .flags(flags), .size_ok(size_ok)
    );

    psw_merge u_merge (
        .psw_q(psw_q), .flags(flags), .flag_sel(flag_sel),
        .and_mask(and_mask), .or_mask(or_mask), .allow_mask(allow_mask),
        .psw_d(psw_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            psw_q <= '0;
        else if (upd_en && size_ok)
            psw_q <= psw_d;
    end

    assign psw = psw_q;

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(psw));
    assert_bad_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && (op_size == '0 || op_size > SIZE_W'(4))) |=> $stable(psw));
    assert_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && size_ok && flag_sel[0] && allow_mask[0] && carry_in) |=> psw[0]);
    assert_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && size_ok && flag_sel[1] && allow_mask[1] && result == '0) |=> psw[1]);
    assert_force_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && size_ok) |=> ((psw & $past(or_mask)) == $past(or_mask)));
    assert_clear_ie_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && size_ok && !and_mask[16] && !or_mask[16]) |=> !psw[16]);
endmodule

// File: tb/psw_flag_unit_bench.sv
module psw_flag_unit_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        upd_en = 0;
    logic [63:0] result = '0;
    logic [2:0]  op_size = '0;
    logic        carry_in = 0;
    logic [3:0]  flag_sel = '0;
    logic [31:0] and_mask = '0, or_mask = '0, allow_mask = '0;
    logic [31:0] psw;

    int checks = 0, errors = 0;
    logic [31:0] exp_psw = '0;

    always #5 clk = ~clk;

    psw_flag_unit u_psw_flag_unit (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .result(result),
        .op_size(op_size), .carry_in(carry_in), .flag_sel(flag_sel),
        .and_mask(and_mask), .or_mask(or_mask), .allow_mask(allow_mask),
        .psw(psw)
    );

    function automatic logic [63:0] pick_result(int i);
        case (i)
            0:  return 64'd0;
            1:  return 64'h7F;
            2:  return 64'h80;
            3:  return -64'sd128;
            4:  return -64'sd129;
            5:  return 64'h100;
            6:  return 64'h7FFF;
            7:  return 64'h8000;
            8:  return 64'hFFFF;
            9:  return 64'h7F_FFFF;
            10: return 64'h80_0000;
            11: return 64'hFFFF_FFFF;
            12: return 64'h7FFF_FFFF;
            13: return 64'h8000_0000;
            14: return -64'sd1;
            default: return 64'h8000_0000_0000_0000;
        endcase
    endfunction

    // expected next PSW from the requirements
    function automatic logic [31:0] model(logic [31:0] cur, logic [63:0] r, int sz,
                                          logic cy, logic [3:0] sel,
                                          logic [31:0] am, logic [31:0] om, logic [31:0] pm);
        longint sr, mx, mn;
        logic [63:0] m;
        logic [31:0] f;
        int w;
        if (sz < 1 || sz > 4) return cur;            // R3
        w  = sz * 8;
        m  = (64'd1 << w) - 64'd1;
        sr = longint'(r);
        mx = (longint'(1) << (w - 1)) - 1;
        mn = -(longint'(1) << (w - 1));
        f  = '0;
        f[0] = cy;                                   // R7
        f[1] = ((r & m) == 64'd0);                   // R4
        f[2] = r[w-1];                               // R5
        f[3] = (sr > mx) || (sr < mn);               // R6
        return ((cur & am) | om) | (f & {28'd0, sel} & pm);  // R8 R9
    endfunction

    task automatic check_psw(string what, logic [3:0] sel);
        logic [31:0] d;
        string tag;
        checks++;
        d = psw ^ exp_psw;
        if (d != 0) begin
            errors++;
            if (d[3:0] != 0 && (d[3:0] & sel) == 0) tag = "R8";
            else if (d[0]) tag = "R7";
            else if (d[1]) tag = "R4";
            else if (d[2]) tag = "R5";
            else if (d[3]) tag = "R6";
            else tag = "R10";
            $display("FAIL %s (%s, R9): psw=%08h expected=%08h", tag, what, psw, exp_psw);
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: psw=%08h expected=finish", psw);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] am, om, pm;
        and_mask = '1; or_mask = 32'hFFFF_FFFF; allow_mask = '1; upd_en = 1; op_size = 3'd1;
        repeat (3) @(negedge clk);
        exp_psw = '0;
        check_psw("reset R1", 4'hF);                 // R1 while reset held
        rst_n = 1;
        upd_en = 0;
        @(negedge clk);
        check_psw("after reset R1", 4'hF);

        for (int sz = 0; sz < 8; sz++) begin
            for (int sel = 0; sel < 16; sel++) begin
                for (int ri = 0; ri < 16; ri++) begin
                    int it;
                    it = sz * 256 + sel * 16 + ri;
                    case (it % 4)
                        0: begin am = 32'hFFFF_FFFF; om = 32'h0;         pm = 32'hFFFF_FFFF; end
                        1: begin am = 32'hFFFF_FFF0; om = 32'h0;         pm = 32'hFFFF_FFFF; end
                        2: begin am = 32'hFFFE_FFF0; om = 32'h0010_0001; pm = 32'h0000_000F; end
                        default: begin am = 32'h0;   om = 32'h0F03_0000; pm = 32'h0000_0005; end
                    endcase
                    result = pick_result(ri); op_size = 3'(sz);
                    carry_in = it[5]; flag_sel = 4'(sel);
                    and_mask = am; or_mask = om; allow_mask = pm;
                    upd_en = 1;
                    exp_psw = model(exp_psw, result, sz, carry_in, flag_sel, am, om, pm);
                    @(negedge clk);
                    check_psw((sz < 1 || sz > 4) ? "bad size R3" : "update", flag_sel);
                    // idle cycle with unrelated inputs: R2
                    upd_en = 0; result = ~result; op_size = 3'd2; carry_in = ~carry_in;
                    and_mask = 32'h0; or_mask = 32'hFFFF_FFFF; allow_mask = '1; flag_sel = 4'hF;
                    @(negedge clk);
                    check_psw("idle R2", 4'hF);
                end
            end
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule